// File: doc/BRIEF.md
# Power-on reset supervisor

This block produces the active-low system reset for a power-management controller. It works from a qualified in-regulation flag for the primary rail, a supply-undervoltage flag, a pushbutton hard-reset request and a one-microsecond tick. After power is applied, it holds reset low while a one-second start-up timer runs. Once that timer has expired, it releases reset as soon as the primary rail is in range.

During normal operation, a brief dip of the rail is filtered out. A dip that lasts for the whole filter window asserts reset, and so does a hard-reset request. Reset is then released only after the rail has stayed in regulation for a full release delay. When the start-up timer expires, the block samples the supply flag. If the supply is still low, it latches an undervoltage status bit that drives an interrupt line until software clears the bit with a write-one-to-clear strobe.

All delays are counted in ticks of the microsecond input. The three tick counts are parameters: 1,000,000 for start-up, 25 for the filter and 14,000 for release.

Top module: `por_supervisor`

## Requirements
- R1: After power-on reset, `rst_out_n` stays 0 until `STARTUP_US` ticks have been counted. After that, it goes to 1 on the second clock edge at which `rail_ok` is 1 and `hard_rst_req` is 0, counting from the edge of the final tick.
- R2: While reset is released, `rail_ok` at 0 for `FILT_US` consecutive ticks drives `rst_out_n` to 0 on the clock edge of the last such tick.
- R3: While reset is released, a loss of regulation that ends before `FILT_US` ticks have passed leaves `rst_out_n` at 1 and restarts the filter count.
- R4: While reset is released, `hard_rst_req` at 1 drives `rst_out_n` to 0 on the next clock edge, whatever the value of `rail_ok`.
- R5: While reset is asserted after start-up, `rst_out_n` returns to 1 on the clock edge of the `RELEASE_US`-th consecutive tick at which `rail_ok` is 1 and `hard_rst_req` is 0.
- R6: During the release delay, any cycle with `rail_ok` at 0 or `hard_rst_req` at 1 restarts the delay from zero.
- R7: If `vin_low` is 1 in the cycle of the final start-up tick, `uv_stat` and `irq` become 1 on that edge.
- R8: A cycle with `uv_clr` at 1 clears `uv_stat` and `irq` on the next edge. If the undervoltage bit is set in that same cycle, the set wins.
- R9: Asserting `rst_n` low at once drives `rst_out_n`, `irq` and `uv_stat` to 0 and restarts the start-up timer from zero.
- R10: `vin_low` has no effect on `uv_stat` except in the cycle of the final start-up tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| rail_ok | input | 1 | Primary rail within its regulation window |
| vin_low | input | 1 | Supply below its undervoltage threshold |
| hard_rst_req | input | 1 | Pushbutton hard-reset request |
| uv_clr | input | 1 | Write-one-to-clear strobe for the undervoltage bit |
| rst_out_n | output | 1 | Active-low system reset |
| irq | output | 1 | Interrupt request, high while the undervoltage bit is set |
| uv_stat | output | 1 | Undervoltage status bit |

## Verification
Two functions can act in the same cycle: the undervoltage set at the final start-up tick and the software clear strobe. The bench drives `uv_clr` high in exactly the cycle that carries the last start-up tick. It expects the bit to be set on that edge and `irq` to stay high once the strobe drops. A second collision is a hard-reset request that arrives together with a filter trip or during the release delay. For that case, the reference model expects the delay to restart.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    PS_BOOT = 2'd0,
    PS_WAIT = 2'd1,
    PS_RUN  = 2'd2,
    PS_HOLD = 2'd3
  } por_state_e;
endpackage

// File: rtl/por_tick_cnt.sv
module por_tick_cnt #(
  parameter int unsigned LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  assign hit = inc && !clr && (cnt_q == W'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (hit) cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5 / R2: the counter wraps at its limit and never runs past it
  a_r5_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < LIMIT);
  // R6: a clear request leaves the count at zero
  a_r6_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/por_seq.sv
module por_seq
  import por_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rail_ok,
  input  logic       hard_req,
  input  logic       su_hit,
  input  logic       flt_hit,
  input  logic       rel_hit,
  output por_state_e st,
  output logic       su_inc,
  output logic       flt_inc,
  output logic       flt_clr,
  output logic       rel_inc,
  output logic       rel_clr
);
  por_state_e st_q, st_d;

  always_comb begin
    su_inc  = (st_q == PS_BOOT) && tick;
    flt_clr = (st_q != PS_RUN) || rail_ok;
    flt_inc = (st_q == PS_RUN) && !rail_ok && tick;
    rel_clr = (st_q != PS_HOLD) || !rail_ok || hard_req;
    rel_inc = (st_q == PS_HOLD) && rail_ok && !hard_req && tick;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_BOOT: if (su_hit)                st_d = PS_WAIT;
      PS_WAIT: if (rail_ok && !hard_req)  st_d = PS_RUN;
      PS_RUN:  if (hard_req || flt_hit)   st_d = PS_HOLD;
      PS_HOLD: if (rel_hit)               st_d = PS_RUN;
      default:                            st_d = PS_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_BOOT;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R1: start-up is left only when the start-up count expires
  a_r1_boot_until_timer: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_BOOT && !su_hit) |=> (st_q == PS_BOOT));
  // R2 / R3: normal operation is left only by a filter trip or a hard request
  a_r2_run_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && !hard_req && !flt_hit) |=> (st_q == PS_RUN));
  // R4: a hard request forces reset on the next edge
  a_r4_hard_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && hard_req) |=> (st_q == PS_HOLD));
  // R5: the hold is left only when the release count completes
  a_r5_hold_until_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HOLD && !rel_hit) |=> (st_q == PS_HOLD));
endmodule

// File: rtl/por_uv_latch.sv
module por_uv_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R8: a clear with no coincident set empties the bit
  a_r8_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
  // R8: a set beats a coincident clear
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
endmodule

// File: rtl/por_supervisor.sv
module por_supervisor
  import por_pkg::*;
#(
  parameter int unsigned STARTUP_US = 1_000_000,
  parameter int unsigned FILT_US    = 25,
  parameter int unsigned RELEASE_US = 14_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic rail_ok,
  input  logic vin_low,
  input  logic hard_rst_req,
  input  logic uv_clr,
  output logic rst_out_n,
  output logic irq,
  output logic uv_stat
);
  por_state_e st;
  logic su_inc, su_hit;
  logic flt_inc, flt_clr, flt_hit;
  logic rel_inc, rel_clr, rel_hit;
  logic uv_q;

  por_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .rail_ok  (rail_ok),
    .hard_req (hard_rst_req),
    .su_hit   (su_hit),
    .flt_hit  (flt_hit),
    .rel_hit  (rel_hit),
    .st       (st),
    .su_inc   (su_inc),
    .flt_inc  (flt_inc),
    .flt_clr  (flt_clr),
    .rel_inc  (rel_inc),
    .rel_clr  (rel_clr)
  );

  por_tick_cnt #(.LIMIT(STARTUP_US)) u_su_cnt (
    .clk (clk), .rst_n (rst_n), .clr (1'b0), .inc (su_inc), .hit (su_hit)
  );

  por_tick_cnt #(.LIMIT(FILT_US)) u_flt_cnt (
    .clk (clk), .rst_n (rst_n), .clr (flt_clr), .inc (flt_inc), .hit (flt_hit)
  );

  por_tick_cnt #(.LIMIT(RELEASE_US)) u_rel_cnt (
    .clk (clk), .rst_n (rst_n), .clr (rel_clr), .inc (rel_inc), .hit (rel_hit)
  );

  por_uv_latch u_uv (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (su_hit && vin_low),
    .clr   (uv_clr),
    .flag  (uv_q)
  );

  assign rst_out_n = (st == PS_RUN);
  assign uv_stat   = uv_q;
  assign irq       = uv_q;

  // R7: undervoltage at the final start-up tick raises the interrupt
  a_r7_uv_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (su_hit && vin_low) |=> irq);
  // R10: the status bit only rises at the end of start-up
  a_r10_rise_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_stat) |-> $past(su_hit));
  // R1: reset is never released directly from the start-up timer
  a_r1_no_release_in_boot: assert property (@(posedge clk) disable iff (!rst_n)
    su_inc |-> !rst_out_n);
endmodule

// File: tb/por_supervisor_test.sv
module por_supervisor_test;
  localparam int SU  = 40;
  localparam int FLT = 5;
  localparam int REL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0, rail_ok = 1'b0, vin_low = 1'b0, hard_rst_req = 1'b0, uv_clr = 1'b0;
  logic rst_out_n, irq, uv_stat;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  string phase = "R9";

  por_supervisor #(.STARTUP_US(SU), .FILT_US(FLT), .RELEASE_US(REL)) uut (
    .clk (clk), .rst_n (rst_n), .tick_us (tick_us), .rail_ok (rail_ok),
    .vin_low (vin_low), .hard_rst_req (hard_rst_req), .uv_clr (uv_clr),
    .rst_out_n (rst_out_n), .irq (irq), .uv_stat (uv_stat)
  );

  always #4 clk = ~clk;

  // reference model: 0 boot, 1 waiting for rail, 2 running, 3 holding
  int m_st, m_su, m_flt, m_rel;
  bit m_uv;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_su = 0; m_flt = 0; m_rel = 0; m_uv = 0;
    end else begin
      bit set_uv;
      set_uv = 0;
      case (m_st)
        0: if (tick_us) begin
             m_su++;
             if (m_su == SU) begin m_st = 1; m_su = 0; set_uv = vin_low; end
           end
        1: if (rail_ok && !hard_rst_req) m_st = 2;
        2: if (hard_rst_req) begin m_st = 3; m_flt = 0; m_rel = 0; end
           else if (!rail_ok) begin
             if (tick_us) begin
               m_flt++;
               if (m_flt == FLT) begin m_st = 3; m_flt = 0; m_rel = 0; end
             end
           end else m_flt = 0;
        default: if (hard_rst_req || !rail_ok) m_rel = 0;
           else if (tick_us) begin
             m_rel++;
             if (m_rel == REL) begin m_st = 2; m_rel = 0; end
           end
      endcase
      if (set_uv) m_uv = 1;
      else if (uv_clr) m_uv = 0;
    end
  end

  task automatic chk(logic got, logic exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at cycle %0d", tag, got, exp, cyc_cnt);
    end
  endtask

  always @(negedge clk) begin
    cyc_cnt++;
    chk(rst_out_n, (m_st == 2), {phase, " rst_out_n vs model"});
    chk(irq, m_uv, {phase, " irq vs model"});
    chk(uv_stat, m_uv, {phase, " uv_stat vs model"});
    if (cyc_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
  end

  task automatic run(int n, int every);
    for (int i = 0; i < n; i++) begin
      tick_us = (every != 0) && (i % every == 0);
      @(posedge clk); #2;
    end
    tick_us = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(rst_out_n, 1'b0, "R9 reset state rst_out_n");
    chk(irq, 1'b0, "R9 reset state irq");
    rst_n = 1'b1;

    phase = "R1";
    rail_ok = 0; vin_low = 1;
    run(45, 1);
    chk(rst_out_n, 1'b0, "R1 held while rail low after timer");
    phase = "R7";
    chk(irq, 1'b1, "R7 uv at end of start-up");
    rail_ok = 1; vin_low = 0;
    run(2, 0);
    chk(rst_out_n, 1'b1, "R1 release once rail in range");

    phase = "R8";
    uv_clr = 1; run(1, 0); uv_clr = 0; run(1, 0);
    chk(irq, 1'b0, "R8 w1c clears irq");

    phase = "R10";
    vin_low = 1; run(10, 1); vin_low = 0;
    chk(uv_stat, 1'b0, "R10 late undervoltage ignored");

    phase = "R3";
    rail_ok = 0; run(4, 1); rail_ok = 1; run(1, 1);
    rail_ok = 0; run(4, 1); rail_ok = 1; run(2, 1);
    chk(rst_out_n, 1'b1, "R3 short dips filtered");

    phase = "R2";
    rail_ok = 0; run(5, 1);
    chk(rst_out_n, 1'b0, "R2 sustained loss asserts reset");

    phase = "R6";
    rail_ok = 1; run(8, 1); rail_ok = 0; run(1, 1); rail_ok = 1; run(8, 1);
    chk(rst_out_n, 1'b0, "R6 dip restarts release delay");
    phase = "R5";
    run(4, 1);
    chk(rst_out_n, 1'b1, "R5 release after full delay");

    phase = "R2";
    rail_ok = 0; run(14, 3);
    chk(rst_out_n, 1'b0, "R2 sparse ticks still trip");
    rail_ok = 1; run(36, 3);
    chk(rst_out_n, 1'b1, "R5 release with sparse ticks");

    phase = "R4";
    hard_rst_req = 1; run(1, 0); hard_rst_req = 0;
    chk(rst_out_n, 1'b0, "R4 hard reset asserts");
    run(6, 1); hard_rst_req = 1; run(1, 1); hard_rst_req = 0; run(11, 1);
    chk(rst_out_n, 1'b0, "R6 hard request restarts delay");
    run(2, 1);
    chk(rst_out_n, 1'b1, "R5 release after restarted delay");
    rail_ok = 0; run(4, 1); hard_rst_req = 1; run(1, 1); hard_rst_req = 0;
    rail_ok = 1; run(1, 0);
    chk(rst_out_n, 1'b0, "R4 hard reset with rail low");
    run(14, 1);

    phase = "R9";
    rst_n = 0; #1;
    chk(rst_out_n, 1'b0, "R9 async reset asserts output");
    run(2, 0); rst_n = 1;
    phase = "R8";
    vin_low = 1;
    run(SU - 1, 1);
    chk(rst_out_n, 1'b0, "R9 start-up timer restarted");
    uv_clr = 1; run(1, 1); uv_clr = 0;
    chk(irq, 1'b1, "R8 set beats coincident clear");
    run(3, 0);
    chk(rst_out_n, 1'b1, "R1 release after second start-up");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule